// File: doc/BRIEF.md
# PCIe Power-Management Command and Hot-Plug Message Interrupt Unit

This unit lives beside a PCIe controller's link layer and gives software a small register window for power-management commands. Software writes single command bits that never hold a value: each write is checked against the controller's role (root complex or endpoint) and, for the L2/L3-ready exit, against the current link state. An accepted command becomes a one-cycle request strobe toward the link layer. A command that fails its check is dropped without trace. The unit then waits for the link layer's acknowledge before it takes the same command again. When the L2/L3-ready exit is acknowledged, a sticky status flag records it. Requesting a PME from an endpoint also sets a sticky PME status flag.

A message decoder outside the unit reports five received hot-plug messages (attention indicator off, power indicator on, power indicator blink, power indicator off, attention button pressed) as single-cycle pulses. The unit latches each one into a detect flag that software clears by writing 1. A per-message enable mask selects which flags drive a level interrupt.

Each of the three commands has its own sequencer with three named states. `SEQ_IDLE` moves to `SEQ_ISSUE` on an accepted command. `SEQ_ISSUE` always moves to `SEQ_AWAIT` after one cycle, and the request strobe is high in that cycle. `SEQ_AWAIT` returns to `SEQ_IDLE` in the cycle its acknowledge is high and otherwise stays. The sequencer is busy in both `SEQ_ISSUE` and `SEQ_AWAIT`.

Top module: `pm_cmd_unit`

Register map (byte offsets; only the bits listed exist, every other bit reads 0 and ignores writes):

| Offset | Register | Bits |
|--------|----------|------|
| 0x2C | command | bit 2 request PME (endpoint only), bit 1 leave L2/L3-ready (root only), bit 0 broadcast turn-off (root only) |
| 0x30 | interrupt enable | bits 4..0, read/write |
| 0x34 | message detect | bits 4..0, write 1 to clear |
| 0x38 | status | bit 0 PME status, bit 1 exited L2/L3-ready; write 1 to clear |

Message bit order, shared by enable and detect: bit 0 attention indicator off, bit 1 power indicator on, bit 2 power indicator blink, bit 3 power indicator off, bit 4 attention button pressed.

## Requirements
- R1: After reset, every register reads 0 and `pme_req`, `l2x_req`, `toff_req` and `irq` are low.
- R2: The command register at 0x2C always reads 0, including right after a write of 1s. Writing its reserved bits 31..3 produces no request strobe.
- R3: In endpoint mode, writing bit 2 of 0x2C sets status bit 0 at that clock edge. When `pme_en` is high and the PME sequencer is in `SEQ_IDLE`, it also drives `pme_req` high for exactly the one cycle after the write.
- R4: In root-complex mode, writing bit 2 of 0x2C has no effect: `pme_req` stays low and status bit 0 stays 0.
- R5: In root-complex mode, writing bit 1 of 0x2C drives `l2x_req` high for exactly the one cycle after the write, but only if `l2_ready` is high at the write edge. Otherwise the command is dropped.
- R6: In endpoint mode, writing bit 1 of 0x2C has no effect, even with `l2_ready` high.
- R7: Status bit 1 is set at the edge where `l2x_ack` is high while the exit sequencer is in `SEQ_AWAIT`. It stays 0 while waiting. An `l2x_ack` that arrives with no exit in progress is ignored.
- R8: Writing bit 0 of 0x2C drives `toff_req` high for exactly one cycle in root-complex mode. In endpoint mode it is dropped.
- R9: A command written while its own sequencer is in `SEQ_ISSUE` or `SEQ_AWAIT` is dropped. After the acknowledge, the same command is accepted again.
- R10: A `msg_pulse` bit sets the matching detect bit at 0x34. Writing 1 to a detect bit clears it. A pulse and a clear on the same bit in the same cycle leave the bit set.
- R11: The enable register at 0x30 stores bits 4..0 as written. Its bits 31..5 read 0.
- R12: `irq` is high exactly when some detect bit and its enable bit are both 1. It follows a register change in the cycle after that change.
- R13: Status bits are cleared by writing 1 to them at 0x38. A set event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_root | input | 1 | 1 = root complex, 0 = endpoint; static after reset |
| pme_en | input | 1 | PME generation enabled |
| l2_ready | input | 1 | Link is in L2/L3-ready |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| msg_pulse | input | N_MSG | One-cycle received-message pulses |
| pme_req | output | 1 | One-cycle PME message request |
| pme_ack | input | 1 | PME message sent |
| l2x_req | output | 1 | One-cycle request to leave L2/L3-ready |
| l2x_ack | input | 1 | Link has left L2/L3-ready |
| toff_req | output | 1 | One-cycle turn-off broadcast request |
| toff_ack | input | 1 | Turn-off broadcast sent |
| irq | output | 1 | Level interrupt from enabled detect flags |

## Verification
The interrupt path is swept over all 32 enable masks against all 32 detect patterns, with the detect register cleared before each pattern. This separates an OR over the wrong bits, a missing enable term and a mask applied in the wrong order, and it also checks that `irq` drops once detect is cleared. Every command bit is written in both roles, which exposes a role gate that is inverted or swapped between commands. The exit command is also written with `l2_ready` low and high, with an acknowledge before and after the request, and with a status clear in the same cycle as the acknowledge. This keeps the state precondition, the sticky status and set-over-clear priority apart. Repeating a command while its sequencer waits, and again after the acknowledge, separates the busy drop from a sequencer that never returns to idle.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_AWAIT = 2'd2
    } seq_state_t;

    // Command bit positions inside the command register (LSB-0)
    localparam int CMD_N    = 3;
    localparam int CMD_TOFF = 0;
    localparam int CMD_EXIT = 1;
    localparam int CMD_PME  = 2;

    // Status bit positions
    localparam int STAT_N    = 2;
    localparam int STAT_PME  = 0;
    localparam int STAT_EXIT = 1;

endpackage

// File: rtl/pm_cmd_seq.sv
module pm_cmd_seq
    import pm_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ack,
    output logic req,
    output logic busy,
    output logic done
);

    seq_state_t st_q;
    seq_state_t st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        req  = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (st_q)
            SEQ_IDLE: begin
                busy = 1'b0;
                if (go) begin
                    st_d = SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                req  = 1'b1;
                st_d = SEQ_AWAIT;
            end
            SEQ_AWAIT: begin
                if (ack) begin
                    done = 1'b1;
                    st_d = SEQ_IDLE;
                end
            end
            default: begin
                st_d = SEQ_IDLE;
            end
        endcase
    end

    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R9
    busy_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

endmodule

// File: rtl/pm_msg_irq.sv
module pm_msg_irq #(
    parameter int N_MSG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MSG-1:0] msg_pulse,
    input  logic             ien_we,
    input  logic             det_clr_we,
    input  logic [N_MSG-1:0] wbits,
    output logic [N_MSG-1:0] ien,
    output logic [N_MSG-1:0] det,
    output logic             irq
);

    logic [N_MSG-1:0] ien_q;
    logic [N_MSG-1:0] det_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (ien_we) begin
            ien_q <= wbits;
        end
    end

    for (genvar gi = 0; gi < N_MSG; gi++) begin : g_det
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                det_q[gi] <= 1'b0;
            end else if (msg_pulse[gi]) begin
                det_q[gi] <= 1'b1;
            end else if (det_clr_we && wbits[gi]) begin
                det_q[gi] <= 1'b0;
            end
        end
    end

    assign ien = ien_q;
    assign det = det_q;
    assign irq = |(det_q & ien_q);

    // R10
    det_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|msg_pulse) |=> ((det_q & $past(msg_pulse)) == $past(msg_pulse)));

    // R12
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

endmodule

// File: rtl/pm_cmd_unit.sv
module pm_cmd_unit
    import pm_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          N_MSG    = 5,
    parameter int unsigned CMD_OFS  = 32'h2C,
    parameter int unsigned IEN_OFS  = 32'h30,
    parameter int unsigned DET_OFS  = 32'h34,
    parameter int unsigned STAT_OFS = 32'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_root,
    input  logic              pme_en,
    input  logic              l2_ready,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_MSG-1:0]  msg_pulse,
    output logic              pme_req,
    input  logic              pme_ack,
    output logic              l2x_req,
    input  logic              l2x_ack,
    output logic              toff_req,
    input  logic              toff_ack,
    output logic              irq
);

    localparam int PAD_MSG  = DATA_W - N_MSG;
    localparam int PAD_STAT = DATA_W - STAT_N;

    // Address decode
    logic hit_cmd, hit_ien, hit_det, hit_stat;
    assign hit_cmd  = (reg_addr == ADDR_W'(CMD_OFS));
    assign hit_ien  = (reg_addr == ADDR_W'(IEN_OFS));
    assign hit_det  = (reg_addr == ADDR_W'(DET_OFS));
    assign hit_stat = (reg_addr == ADDR_W'(STAT_OFS));

    logic wr_cmd, wr_stat;
    assign wr_cmd  = reg_we && hit_cmd;
    assign wr_stat = reg_we && hit_stat;

    // Command gating and sequencers
    logic [CMD_N-1:0] allow, go, ack, req, busy, done;

    assign allow[CMD_TOFF] = is_root;
    assign allow[CMD_EXIT] = is_root && l2_ready;
    assign allow[CMD_PME]  = !is_root && pme_en;

    assign ack[CMD_TOFF] = toff_ack;
    assign ack[CMD_EXIT] = l2x_ack;
    assign ack[CMD_PME]  = pme_ack;

    for (genvar gi = 0; gi < CMD_N; gi++) begin : g_cmd
        assign go[gi] = wr_cmd && reg_wdata[gi] && allow[gi] && !busy[gi];

        pm_cmd_seq u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (go[gi]),
            .ack   (ack[gi]),
            .req   (req[gi]),
            .busy  (busy[gi]),
            .done  (done[gi])
        );
    end

    assign pme_req  = req[CMD_PME];
    assign l2x_req  = req[CMD_EXIT];
    assign toff_req = req[CMD_TOFF];

    // Sticky status flags, set wins over write-1-to-clear
    logic pme_stat_q, exited_q, pme_set;
    assign pme_set = wr_cmd && reg_wdata[CMD_PME] && !is_root;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pme_stat_q <= 1'b0;
            exited_q   <= 1'b0;
        end else begin
            if (pme_set) begin
                pme_stat_q <= 1'b1;
            end else if (wr_stat && reg_wdata[STAT_PME]) begin
                pme_stat_q <= 1'b0;
            end
            if (done[CMD_EXIT]) begin
                exited_q <= 1'b1;
            end else if (wr_stat && reg_wdata[STAT_EXIT]) begin
                exited_q <= 1'b0;
            end
        end
    end

    // Message detect and interrupt
    logic [N_MSG-1:0] ien_bits, det_bits;

    pm_msg_irq #(
        .N_MSG (N_MSG)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_pulse  (msg_pulse),
        .ien_we     (reg_we && hit_ien),
        .det_clr_we (reg_we && hit_det),
        .wbits      (reg_wdata[N_MSG-1:0]),
        .ien        (ien_bits),
        .det        (det_bits),
        .irq        (irq)
    );

    // Read mux; the command register never holds a value
    always_comb begin
        reg_rdata = '0;
        if (hit_ien) begin
            reg_rdata = {{PAD_MSG{1'b0}}, ien_bits};
        end else if (hit_det) begin
            reg_rdata = {{PAD_MSG{1'b0}}, det_bits};
        end else if (hit_stat) begin
            reg_rdata = {{PAD_STAT{1'b0}}, exited_q, pme_stat_q};
        end
    end

    // R4
    rc_no_pme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_root |-> !pme_req);

    // R6 and R8
    ep_no_rootcmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_root |-> (!l2x_req && !toff_req));

    // R5
    exit_needs_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l2x_req) |-> $past(l2_ready));

    // R7
    exited_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exited_q) |-> $past(l2x_ack));

endmodule

// File: tb/pm_cmd_unit_bench.sv
module pm_cmd_unit_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int N_MSG  = 5;
    localparam logic [ADDR_W-1:0] A_CMD  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h30;
    localparam logic [ADDR_W-1:0] A_DET  = 8'h34;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h38;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              is_root = 1'b0;
    logic              pme_en = 1'b0;
    logic              l2_ready = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [N_MSG-1:0]  msg_pulse = '0;
    logic              pme_req, l2x_req, toff_req, irq;
    logic              pme_ack = 1'b0, l2x_ack = 1'b0, toff_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pm_cmd_unit u_pm_cmd_unit (
        .clk(clk), .rst_n(rst_n), .is_root(is_root), .pme_en(pme_en),
        .l2_ready(l2_ready), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_pulse(msg_pulse),
        .pme_req(pme_req), .pme_ack(pme_ack), .l2x_req(l2x_req),
        .l2x_ack(l2x_ack), .toff_req(toff_req), .toff_ack(toff_ack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset(input logic root);
        rst_n = 1'b0; is_root = root; pme_en = 1'b0; l2_ready = 1'b0;
        pme_ack = 1'b0; l2x_ack = 1'b0; toff_ack = 1'b0; msg_pulse = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    function automatic logic [2:0] reqs();
        return {pme_req, l2x_req, toff_req};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;

        // ---------------- endpoint ----------------
        do_reset(1'b0);
        // R1
        rd(A_CMD, v);  chk("R1 cmd reset", v, 0);
        rd(A_IEN, v);  chk("R1 ien reset", v, 0);
        rd(A_DET, v);  chk("R1 det reset", v, 0);
        rd(A_STAT, v); chk("R1 stat reset", v, 0);
        chk("R1 outputs reset", {28'd0, reqs(), irq}, 0);

        // R3 PME request with enable
        pme_en = 1'b1;
        wr(A_CMD, 32'h4);
        chk("R3 pme_req pulse", {29'd0, reqs()}, 32'h4);
        rd(A_STAT, v); chk("R3 pme status set", v, 1);
        rd(A_CMD, v);  chk("R2 cmd reads 0 after write", v, 0);
        tick();
        chk("R3 pme_req one cycle", {29'd0, reqs()}, 0);
        // R9 busy drop
        wr(A_CMD, 32'h4);
        chk("R9 pme dropped while waiting", {29'd0, reqs()}, 0);
        pme_ack = 1'b1; tick(); pme_ack = 1'b0;
        wr(A_CMD, 32'h4);
        chk("R9 pme accepted after ack", {29'd0, reqs()}, 32'h4);
        tick();
        pme_ack = 1'b1; tick(); pme_ack = 1'b0;

        // R13 clear, R3 without pme_en
        wr(A_STAT, 32'h1);
        rd(A_STAT, v); chk("R13 pme status cleared", v, 0);
        pme_en = 1'b0;
        wr(A_CMD, 32'h4);
        chk("R3 no pulse with pme_en low", {29'd0, reqs()}, 0);
        rd(A_STAT, v); chk("R3 status set with pme_en low", v, 1);

        // R6, R8 endpoint drops root-only commands
        l2_ready = 1'b1;
        wr(A_CMD, 32'h2);
        chk("R6 exit dropped in endpoint", {29'd0, reqs()}, 0);
        tick();
        chk("R6 exit still silent", {29'd0, reqs()}, 0);
        wr(A_CMD, 32'h1);
        chk("R8 turn-off dropped in endpoint", {29'd0, reqs()}, 0);
        tick();
        chk("R8 turn-off still silent", {29'd0, reqs()}, 0);

        // R2 reserved bits
        wr(A_STAT, 32'h3);
        pme_en = 1'b1;
        wr(A_CMD, 32'hFFFF_FFF8);
        chk("R2 reserved write no request", {29'd0, reqs()}, 0);
        rd(A_STAT, v); chk("R2 reserved write no status", v, 0);
        rd(A_CMD, v);  chk("R2 cmd reads 0", v, 0);

        // ---------------- root complex ----------------
        do_reset(1'b1);
        pme_en = 1'b1;
        // R4
        wr(A_CMD, 32'h4);
        chk("R4 pme ignored in root", {29'd0, reqs()}, 0);
        rd(A_STAT, v); chk("R4 pme status untouched", v, 0);
        // R5 precondition
        l2_ready = 1'b0;
        wr(A_CMD, 32'h2);
        chk("R5 exit dropped without l2_ready", {29'd0, reqs()}, 0);
        tick();
        chk("R5 exit still dropped", {29'd0, reqs()}, 0);
        // R7 stray ack ignored
        l2x_ack = 1'b1; tick(); l2x_ack = 1'b0;
        rd(A_STAT, v); chk("R7 stray ack ignored", v, 0);
        l2_ready = 1'b1;
        wr(A_CMD, 32'h2);
        chk("R5 exit pulse", {29'd0, reqs()}, 32'h2);
        tick();
        chk("R5 exit one cycle", {29'd0, reqs()}, 0);
        rd(A_STAT, v); chk("R7 no status before ack", v, 0);
        l2x_ack = 1'b1; tick(); l2x_ack = 1'b0;
        rd(A_STAT, v); chk("R7 exited status set", v, 32'h2);
        tick();
        rd(A_STAT, v); chk("R7 exited status sticky", v, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, v); chk("R13 exited status cleared", v, 0);
        // R13 set wins over clear
        wr(A_CMD, 32'h2);
        tick();
        l2x_ack = 1'b1;
        wr(A_STAT, 32'h2);
        l2x_ack = 1'b0;
        rd(A_STAT, v); chk("R13 set wins over clear", v, 32'h2);
        // R8 turn-off in root
        wr(A_CMD, 32'h1);
        chk("R8 turn-off pulse", {29'd0, reqs()}, 32'h1);
        tick();
        chk("R8 turn-off one cycle", {29'd0, reqs()}, 0);
        wr(A_CMD, 32'h1);
        chk("R9 turn-off dropped while waiting", {29'd0, reqs()}, 0);
        toff_ack = 1'b1; tick(); toff_ack = 1'b0;
        wr(A_CMD, 32'h1);
        chk("R9 turn-off accepted after ack", {29'd0, reqs()}, 32'h1);

        // R10 detect flags
        msg_pulse = 5'b10101; tick(); msg_pulse = '0;
        rd(A_DET, v); chk("R10 detect capture", v, 32'h15);
        wr(A_DET, 32'h1);
        rd(A_DET, v); chk("R10 detect w1c", v, 32'h14);
        msg_pulse = 5'b00100;
        wr(A_DET, 32'h4);
        msg_pulse = '0;
        rd(A_DET, v); chk("R10 pulse wins over clear", v, 32'h14);
        wr(A_DET, 32'h1F);
        rd(A_DET, v); chk("R10 detect all cleared", v, 0);

        // R11
        wr(A_IEN, 32'hFFFF_FFFF);
        rd(A_IEN, v); chk("R11 enable width", v, 32'h1F);
        wr(A_IEN, 32'h0A);
        rd(A_IEN, v); chk("R11 enable pattern", v, 32'h0A);

        // R12 full sweep
        for (int e = 0; e < 32; e++) begin
            wr(A_IEN, 32'(e));
            for (int d = 0; d < 32; d++) begin
                wr(A_DET, 32'h1F);
                chk($sformatf("R12 irq low after clear e=%0d", e), {31'd0, irq}, 0);
                msg_pulse = 5'(d); tick(); msg_pulse = '0;
                chk($sformatf("R12 irq e=%0d d=%0d", e, d), {31'd0, irq},
                    {31'd0, ((e & d) != 0)});
            end
        end

        finish_run();
    end

endmodule